// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a 32-bit down-counting timer for one processor core. Software sets it up through a small word-addressed register bus. A reload value sets the starting count. A control word holds four things: a run bit, a mode bit that selects repeating or single-shot operation, an interrupt-gate bit and an 8-bit clock divider. The counter moves one step for every divider+1 pulses of a base tick-enable input. When it expires it sets a sticky flag, and that flag drives a level interrupt through the gate bit. Software can read the live count at any time.

A value of zero written to the reload value or to the counter needs care. With the divider at zero, such a write either halts the timer without an interrupt or takes the reload value in its place. With a nonzero divider, a zero value instead makes the timer expire once per divided step. Starting the timer never makes it expire at once. In repeating mode the counter sits at zero for one step before it takes the reload value again.

Top module: `cdt_timer`

## Requirements
- R1: Word offsets: 0x0 reload value, 0x4 live counter, 0x8 control, 0xC status (bit 0). A read of any other offset, or of an offset that is not a multiple of four, returns 0. A write is accepted only when all four byte enables are set and the offset is word aligned.
- R2: Control layout: bit 0 run, bit 1 repeat mode, bit 2 interrupt gate, bits 15:8 divider D. Any other bits read back as 0. While running, the counter moves one step per D+1 cycles of tickEn=1, and cycles with tickEn=0 do not advance it.
- R3: Expiry sets status bit 0. The irq output equals status AND the interrupt gate.
- R4: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged.
- R5: The counter moves only while the run bit is set and either D is nonzero or the count that was started is nonzero. A stopped counter holds its value.
- R6: A write to the reload value also loads the counter and restarts the divider. If it writes 0 while running with D=0, the counter stops and no interrupt is raised.
- R7: A counter write of 0 while running with D=0 stops the counter silently in single-shot mode, or when the reload value is 0. In repeating mode with a nonzero reload value, it loads the reload value instead.
- R8: A control write that changes the run or mode bit stops the counter first. A write that leaves the timer running in repeating mode with D=0 and a count of 0 first copies the reload value into the counter, and the counter then restarts if the run rule allows.
- R9: In repeating mode, the step that moves the count from 1 to 0 expires. The next step loads the reload value and does not expire, so the period is reload+1 steps.
- R10: In repeating mode with a reload value of 0: with D=0 the timer stops after it expires, and with D nonzero it expires on every step.
- R11: In single-shot mode the timer expires on the step that reaches 0, then stops and holds 0. Starting the timer raises no interrupt in the start cycle.
- R12: Reset clears the control word, status, reload value and counter, and leaves the timer stopped.
- R13: A control write that changes D restarts the divider count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Base tick enable that the divider counts |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte offset of the access |
| busByteEn | input | 4 | Byte enables; a write needs all four |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the offset |
| irqOut | output | 1 | Level interrupt |

## Verification
Every register updates at the clock edge that ends the write or tick cycle. Read data is combinational, so the value at an offset is visible as soon as that edge has passed. The irq output is a gate of two registers and carries no extra delay. An expiry is therefore visible one edge after the tick cycle that ends the count, and a reload from the reload value appears one tick-edge after that. The bench drives each stimulus between edges and lets exactly one edge pass. It then reads every register and irq before the next edge and compares them with a cycle-stepped model built from the rules above. Directed sequences count out the divider windows and the zero-value cases explicitly.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int PRESC_W   = 8;
  localparam int OFF_LOAD  = 'h0;
  localparam int OFF_COUNT = 'h4;
  localparam int OFF_CTRL  = 'h8;
  localparam int OFF_STAT  = 'hC;
  localparam int BIT_RUN   = 0;
  localparam int BIT_RPT   = 1;
  localparam int BIT_GATE  = 2;
  localparam int PRESC_LSB = 8;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic               irqGate;
    logic               repeatMode;
    logic               run;
  } ctrlFields_t;

  typedef struct packed {
    logic setLoad;    // reload value and counter take the bus word
    logic setCount;   // counter takes the bus word
    logic copyLoad;   // counter takes the reload value
    logic decrement;  // counter moves one step down
  } dpStrobe_t;
endpackage

// File: rtl/cdt_datapath.sv
module cdt_datapath
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrValue,
  output logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] countVal,
  output logic              countZero,
  output logic              countOne,
  output logic              loadZero
);
  logic [DATA_W-1:0] loadQ, countQ, countD, loadD;

  always_comb begin
    loadD  = loadQ;
    countD = countQ;
    if (strobe.setLoad) begin
      loadD  = wrValue;
      countD = wrValue;
    end else if (strobe.setCount) begin
      countD = wrValue;
    end else if (strobe.copyLoad) begin
      countD = loadQ;
    end else if (strobe.decrement) begin
      countD = countQ - DATA_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadQ  <= '0;
      countQ <= '0;
    end else begin
      loadQ  <= loadD;
      countQ <= countD;
    end
  end

  assign loadVal   = loadQ;
  assign countVal  = countQ;
  assign countZero = (countQ == '0);
  assign countOne  = (countQ == DATA_W'(1));
  assign loadZero  = (loadQ == '0);

  // R5: without a strobe the counter holds
  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> $stable(countQ));
  // R9: control never steps the counter below zero
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decrement |-> !countZero);
endmodule

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busByteEn,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] loadVal,
  input  logic [DATA_W-1:0] countVal,
  input  logic              countZero,
  input  logic              countOne,
  input  logic              loadZero,
  output dpStrobe_t         strobe,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  ctrlFields_t        ctrlQ, ctrlD, newCtrl;
  logic               statusQ, statusD;
  logic               runQ, runD;
  logic [PRESC_W-1:0] prescCntQ, prescCntD;
  logic               aligned, wrAcc;
  logic               hitLoad, hitCount, hitCtrl, hitStat;
  logic               wrLoad, wrCount, wrCtrl, wrStat;
  logic               wValZero, prescNZ, modeChange, effZero, expire;

  assign aligned  = (busAddr[1:0] == 2'b00);
  assign wrAcc    = busSel && busWr && (&busByteEn) && aligned;
  assign hitLoad  = (busAddr == ADDR_W'(OFF_LOAD));
  assign hitCount = (busAddr == ADDR_W'(OFF_COUNT));
  assign hitCtrl  = (busAddr == ADDR_W'(OFF_CTRL));
  assign hitStat  = (busAddr == ADDR_W'(OFF_STAT));
  assign wrLoad   = wrAcc && hitLoad;
  assign wrCount  = wrAcc && hitCount;
  assign wrCtrl   = wrAcc && hitCtrl;
  assign wrStat   = wrAcc && hitStat;
  assign wValZero = (busWdata == '0);
  assign prescNZ  = (ctrlQ.presc != '0);

  always_comb begin
    newCtrl.run        = busWdata[BIT_RUN];
    newCtrl.repeatMode = busWdata[BIT_RPT];
    newCtrl.irqGate    = busWdata[BIT_GATE];
    newCtrl.presc      = busWdata[PRESC_LSB +: PRESC_W];
  end

  always_comb begin
    strobe     = '0;
    ctrlD      = ctrlQ;
    statusD    = statusQ;
    runD       = runQ;
    prescCntD  = prescCntQ;
    expire     = 1'b0;
    modeChange = 1'b0;
    effZero    = 1'b0;
    if (wrLoad) begin
      strobe.setLoad = 1'b1;
      prescCntD      = '0;
      runD           = ctrlQ.run && (prescNZ || !wValZero);
    end else if (wrCount) begin
      if (ctrlQ.run && ctrlQ.repeatMode && !prescNZ && wValZero) begin
        strobe.copyLoad = 1'b1;
        effZero         = loadZero;
      end else begin
        strobe.setCount = 1'b1;
        effZero         = wValZero;
      end
      prescCntD = '0;
      runD      = ctrlQ.run && (prescNZ || !effZero);
    end else if (wrCtrl) begin
      modeChange = (newCtrl.run != ctrlQ.run) ||
                   (newCtrl.repeatMode != ctrlQ.repeatMode);
      effZero    = countZero;
      if (newCtrl.run && newCtrl.repeatMode && countZero && newCtrl.presc == '0) begin
        strobe.copyLoad = 1'b1;
        effZero         = loadZero;
      end
      runD = newCtrl.run &&
             ((!modeChange && runQ) || (newCtrl.presc != '0) || !effZero);
      if (newCtrl.presc != ctrlQ.presc) prescCntD = '0;
      ctrlD = newCtrl;
    end else if (wrStat) begin
      if (busWdata[0]) statusD = 1'b0;
    end else if (runQ && tickEn) begin
      if (prescCntQ == ctrlQ.presc) begin
        prescCntD = '0;
        if (countOne) begin
          strobe.decrement = 1'b1;
          expire           = 1'b1;
          if (!ctrlQ.repeatMode || (loadZero && !prescNZ)) runD = 1'b0;
        end else if (countZero) begin
          if (!ctrlQ.repeatMode) begin
            expire = 1'b1;
            runD   = 1'b0;
          end else begin
            strobe.copyLoad = 1'b1;
            if (loadZero) begin
              expire = 1'b1;
              if (!prescNZ) runD = 1'b0;
            end
          end
        end else begin
          strobe.decrement = 1'b1;
        end
      end else begin
        prescCntD = prescCntQ + PRESC_W'(1);
      end
    end
    if (expire) statusD = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ     <= '0;
      statusQ   <= 1'b0;
      runQ      <= 1'b0;
      prescCntQ <= '0;
    end else begin
      ctrlQ     <= ctrlD;
      statusQ   <= statusD;
      runQ      <= runD;
      prescCntQ <= prescCntD;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busSel && aligned) begin
      if (hitLoad)       busRdata = loadVal;
      else if (hitCount) busRdata = countVal;
      else if (hitCtrl)  busRdata = DATA_W'({ctrlQ.presc, 5'b00000,
                                             ctrlQ.irqGate, ctrlQ.repeatMode, ctrlQ.run});
      else if (hitStat)  busRdata = DATA_W'(statusQ);
    end
  end

  assign irqOut = statusQ && ctrlQ.irqGate;

  assert_expiry_flags_R3: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> statusQ);
  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && busWdata[0]) |=> !statusQ);
  assert_stopped_when_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ.run |-> !runQ);
  assert_presc_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    prescCntQ <= ctrlQ.presc);
  assert_zero_load_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrLoad && wValZero && ctrlQ.run && !prescNZ) |=> (!runQ && $stable(statusQ)));
  assert_single_shot_halts_R11: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !ctrlQ.repeatMode) |=> !runQ);
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busByteEn,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  dpStrobe_t         strobe;
  logic [DATA_W-1:0] loadVal, countVal;
  logic              countZero, countOne, loadZero;

  cdt_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busByteEn(busByteEn), .busWdata(busWdata),
    .loadVal(loadVal), .countVal(countVal),
    .countZero(countZero), .countOne(countOne), .loadZero(loadZero),
    .strobe(strobe), .busRdata(busRdata), .irqOut(irqOut)
  );

  cdt_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrValue(busWdata),
    .loadVal(loadVal), .countVal(countVal),
    .countZero(countZero), .countOne(countOne), .loadZero(loadZero)
  );
endmodule

// File: tb/cdt_timer_bench.sv
module cdt_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [3:0]  busByteEn = 4'hF;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] mLoad, mCount;
  logic [7:0]  mPs, mPc;
  logic        mEn, mRel, mIe, mStat, mRun;

  cdt_timer u_cdt_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busByteEn(busByteEn), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  task automatic modelReset();
    mLoad = 0; mCount = 0; mPs = 0; mPc = 0;
    mEn = 0; mRel = 0; mIe = 0; mStat = 0; mRun = 0;
  endtask

  task automatic expectVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    v = busRdata;
    busSel = 1'b0;
  endtask

  task automatic checkAll(input string tag);
    logic [31:0] v;
    rd(5'h00, v); expectVal({tag, " load"}, v, mLoad);
    rd(5'h04, v); expectVal({tag, " count"}, v, mCount);
    rd(5'h08, v); expectVal({tag, " ctrl"}, v, {16'h0, mPs, 5'h0, mIe, mRel, mEn});
    rd(5'h0C, v); expectVal({tag, " status"}, v, {31'h0, mStat});
    expectVal({tag, " irq"}, {31'h0, irqOut}, {31'h0, mStat && mIe});
  endtask

  // one clock cycle: inputs held across exactly one rising edge
  task automatic cyc(input logic wr, input logic [4:0] a, input logic [3:0] be,
                     input logic [31:0] d, input logic tk);
    logic [31:0] nL, nC, v;
    logic [7:0]  nPs, nPc;
    logic        nEn, nRel, nIe, nSt, nRun, acc, chg, fire;
    nL = mLoad; nC = mCount; nPs = mPs; nPc = mPc; nEn = mEn; nRel = mRel;
    nIe = mIe; nSt = mStat; nRun = mRun; fire = 0;
    acc = wr && (be == 4'hF) && (a[1:0] == 2'b00);
    if (acc && a == 5'h00) begin
      nL = d; nC = d; nPc = 0; nRun = mEn && (mPs != 0 || d != 0);
    end else if (acc && a == 5'h04) begin
      v = d;
      if (mEn && mRel && mPs == 0 && d == 0) v = mLoad;
      nC = v; nPc = 0; nRun = mEn && (mPs != 0 || v != 0);
    end else if (acc && a == 5'h08) begin
      nEn = d[0]; nRel = d[1]; nIe = d[2]; nPs = d[15:8];
      chg = (nEn != mEn) || (nRel != mRel);
      if (nEn && nRel && mCount == 0 && nPs == 0) nC = mLoad;
      nRun = nEn && ((!chg && mRun) || nPs != 0 || nC != 0);
      if (nPs != mPs) nPc = 0;
    end else if (acc && a == 5'h0C) begin
      if (d[0]) nSt = 0;
    end else if (mRun && tk) begin
      if (mPc == mPs) begin
        nPc = 0;
        if (mCount == 1) begin
          nC = 0; fire = 1;
          if (!mRel || (mLoad == 0 && mPs == 0)) nRun = 0;
        end else if (mCount == 0) begin
          if (!mRel) begin fire = 1; nRun = 0; end
          else begin
            nC = mLoad;
            if (mLoad == 0) begin fire = 1; if (mPs == 0) nRun = 0; end
          end
        end else nC = mCount - 1;
      end else nPc = mPc + 1;
    end
    if (fire) nSt = 1;
    busSel = wr; busWr = wr; busAddr = a; busByteEn = be; busWdata = d; tickEn = tk;
    @(posedge clk);
    #2;
    mLoad = nL; mCount = nC; mPs = nPs; mPc = nPc; mEn = nEn; mRel = nRel;
    mIe = nIe; mStat = nSt; mRun = nRun;
    busSel = 0; busWr = 0; tickEn = 0; busByteEn = 4'hF;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cyc(1'b1, a, 4'hF, d, 1'b0);
  endtask

  task automatic ticks(input int n, input logic tk);
    for (int i = 0; i < n; i++) cyc(1'b0, 5'h00, 4'hF, 32'h0, tk);
  endtask

  task automatic rdExpect(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    expectVal(tag, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [4:0]  a;
    logic [3:0]  be;
    int r;
    void'($urandom(32'd4242));
    modelReset();
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    checkAll("R12 reset");

    // R1: map, partial and unaligned writes, unmapped reads
    wr(5'h00, 32'h0000_0009);
    rdExpect("R1 load readback", 5'h00, 32'h9);
    cyc(1'b1, 5'h00, 4'h3, 32'h55, 1'b0);
    rdExpect("R1 partial write ignored", 5'h00, 32'h9);
    cyc(1'b1, 5'h01, 4'hF, 32'h77, 1'b0);
    rdExpect("R1 unaligned write ignored", 5'h00, 32'h9);
    wr(5'h10, 32'hFFFF_FFFF);
    rdExpect("R1 unmapped read", 5'h10, 32'h0);
    rdExpect("R1 unaligned read", 5'h05, 32'h0);
    wr(5'h08, 32'hFFFF_00F8);
    rdExpect("R2 ctrl reserved bits", 5'h08, 32'h0);

    // R9 periodic wrap, R4 clear, R3 gating
    wr(5'h00, 32'd3);
    wr(5'h08, 32'h7);
    rdExpect("R11 no expiry at start", 5'h0C, 32'h0);
    ticks(3, 1'b1);
    rdExpect("R9 reaches zero", 5'h04, 32'h0);
    rdExpect("R9 expiry status", 5'h0C, 32'h1);
    expectVal("R3 irq high", {31'h0, irqOut}, 32'h1);
    wr(5'h0C, 32'h0);
    rdExpect("R4 write 0 keeps", 5'h0C, 32'h1);
    wr(5'h0C, 32'h1);
    rdExpect("R4 write 1 clears", 5'h0C, 32'h0);
    ticks(1, 1'b1);
    rdExpect("R9 reload value", 5'h04, 32'd3);
    rdExpect("R9 no fire on reload", 5'h0C, 32'h0);
    wr(5'h08, 32'h3);
    ticks(3, 1'b1);
    rdExpect("R3 status set", 5'h0C, 32'h1);
    expectVal("R3 irq gated off", {31'h0, irqOut}, 32'h0);
    wr(5'h08, 32'h7);
    expectVal("R3 irq gated on", {31'h0, irqOut}, 32'h1);
    checkAll("R9 model");

    // R2 divider, R11 single shot
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'h1);
    wr(5'h00, 32'd5);
    wr(5'h08, 32'h0201);
    ticks(2, 1'b1);
    rdExpect("R2 divider hold", 5'h04, 32'd5);
    ticks(1, 1'b1);
    rdExpect("R2 divider step", 5'h04, 32'd4);
    ticks(3, 1'b0);
    rdExpect("R2 tick gating", 5'h04, 32'd4);
    ticks(12, 1'b1);
    rdExpect("R11 reaches zero", 5'h04, 32'd0);
    rdExpect("R11 expiry", 5'h0C, 32'h1);
    wr(5'h0C, 32'h1);
    ticks(6, 1'b1);
    rdExpect("R11 holds zero", 5'h04, 32'd0);
    rdExpect("R11 no refire", 5'h0C, 32'h0);

    // R13 divider restart on change
    wr(5'h08, 32'h0);
    wr(5'h00, 32'd100);
    wr(5'h08, 32'h0301);
    ticks(2, 1'b1);
    wr(5'h08, 32'h0201);
    ticks(2, 1'b1);
    rdExpect("R13 restart hold", 5'h04, 32'd100);
    ticks(1, 1'b1);
    rdExpect("R13 restart step", 5'h04, 32'd99);

    // R6 zero reload value
    wr(5'h08, 32'h1);
    wr(5'h0C, 32'h1);
    wr(5'h00, 32'h0);
    ticks(5, 1'b1);
    rdExpect("R6 zero load count", 5'h04, 32'h0);
    rdExpect("R6 zero load silent", 5'h0C, 32'h0);
    wr(5'h08, 32'h0101);
    wr(5'h00, 32'h0);
    ticks(2, 1'b1);
    rdExpect("R5 divider runs zero count", 5'h0C, 32'h1);
    checkAll("R6 model");

    // R7 zero counter writes
    wr(5'h0C, 32'h1);
    wr(5'h08, 32'h0);
    wr(5'h00, 32'd7);
    wr(5'h08, 32'h3);
    wr(5'h04, 32'h0);
    rdExpect("R7 periodic zero reloads", 5'h04, 32'd7);
    wr(5'h08, 32'h1);
    wr(5'h04, 32'h0);
    ticks(4, 1'b1);
    rdExpect("R7 single zero count", 5'h04, 32'd0);
    rdExpect("R7 single zero silent", 5'h0C, 32'h0);

    // R8 control writes
    wr(5'h08, 32'h0);
    wr(5'h04, 32'h0);
    wr(5'h08, 32'h3);
    rdExpect("R8 periodic start reload", 5'h04, 32'd7);
    wr(5'h08, 32'h0);
    ticks(3, 1'b1);
    rdExpect("R8 mode change stops", 5'h04, 32'd7);

    // R10 zero reload value in repeating mode
    wr(5'h00, 32'h0);
    wr(5'h08, 32'h0103);
    ticks(2, 1'b1);
    rdExpect("R10 divided refire 1", 5'h0C, 32'h1);
    wr(5'h0C, 32'h1);
    ticks(2, 1'b1);
    rdExpect("R10 divided refire 2", 5'h0C, 32'h1);
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'h1);
    wr(5'h04, 32'd2);
    wr(5'h08, 32'h3);
    ticks(2, 1'b1);
    rdExpect("R10 undivided expiry", 5'h0C, 32'h1);
    wr(5'h0C, 32'h1);
    ticks(4, 1'b1);
    rdExpect("R10 undivided stopped", 5'h0C, 32'h0);
    rdExpect("R10 undivided count", 5'h04, 32'h0);
    checkAll("R10 model");

    // random mix checked against the model
    for (int it = 0; it < 700; it++) begin
      r = $urandom % 10;
      if (r < 6) begin
        cyc(1'b0, 5'h00, 4'hF, 32'h0, 1'($urandom % 4 != 0));
      end else begin
        a  = 5'(($urandom % 5) * 4);
        be = ($urandom % 8 == 0) ? 4'h7 : 4'hF;
        case (a)
          5'h08:   d = (32'($urandom % 3) << 8) | 32'($urandom % 8);
          5'h0C:   d = 32'($urandom % 2);
          default: d = 32'($urandom % 6);
        endcase
        cyc(1'b1, a, be, d, 1'($urandom % 2));
      end
      checkAll("R5 random");
    end

    // R12 reset while running
    wr(5'h00, 32'd9);
    wr(5'h08, 32'h0107);
    ticks(3, 1'b1);
    rstN = 1'b0;
    @(posedge clk);
    #2;
    rstN = 1'b1;
    modelReset();
    checkAll("R12 reset mid run");
    ticks(4, 1'b1);
    rdExpect("R12 stays stopped", 5'h04, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule